// File: doc/BRIEF.md
# Base-Deviation Unsigned Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product. It uses a single narrow multiplier rather than a full-width array. The two high bits of each operand select a power-of-two anchor for it: zero, 2^(N-2), 2^(N-1) or 2^N. The operand is then rewritten as that anchor plus or minus a deviation that always fits in N-2 bits. The two deviations are multiplied in one (N-2)×(N-2) multiplier. The product is rebuilt from that narrow result, shifted copies of the operands and deviations, and a sign choice taken from the two operand classes.

A parameter selects the latency. With zero latency the product is combinational. With a latency of one, a single output register holds the product and a valid flag, and that register has a synchronous active-high reset. The width N is a parameter. It must be even and at least 4.

Top module: `base_dev_mul`

## Requirements
- R1: For every pair of unsigned N-bit operands, `p` equals the exact product a×b.
- R2: An operand whose top two bits are 11 and whose low N-2 bits are nonzero is handled as 2^N minus the two's complement of its low bits. For example, operands of all ones give (2^N−1)^2.
- R3: An operand whose top bits are 11 and whose low N-2 bits are all zero (value 3·2^(N-2)) still gives the exact product.
- R4: Operands below 2^(N-2) (top bits 00) have a zero anchor, and their product is exact.
- R5: For N=4, operands 11 (top bits 10) and 3 (top bits 00) give 33.
- R6: With LATENCY=1, `p` and `out_valid` show, one clock after a rising edge, the product of the `a`,`b` and the `in_valid` sampled at that edge.
- R7: With LATENCY=1, a clock edge with `rst` high clears `p` to zero and `out_valid` to 0, whatever the inputs are.
- R8: With LATENCY=0, `p` follows `a` and `b` combinationally, and `out_valid` equals `in_valid` with no clock.
- R9: A zero operand gives `p` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Marks the operands as valid |
| a | input | N | Unsigned operand A |
| b | input | N | Unsigned operand B |
| out_valid | output | 1 | Valid flag aligned with `p` |
| p | output | 2N | Unsigned product |

## Verification
The operand class, the anchor shift, the deviation sign and the deviation value all live only in combinational decode. A wrong value in any of them shows at `p` as a wrong product for every operand pair in the affected class. This shows in the same cycle with zero latency, or one clock later with the register. The exhaustive sweeps at N=4 and N=8 cover every pairing of the four classes, including the class-11 value with zero low bits. At N=16, corner values and random pairs catch errors that only wide shifts expose. A mistake in the output register shows as `out_valid` out of step with `in_valid` by one cycle, or as a stale nonzero product after reset.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    // Operand class selected by the two most significant operand bits.
    typedef enum logic [1:0] {
        CLS_SMALL   = 2'b00,
        CLS_QUARTER = 2'b01,
        CLS_HALF    = 2'b10,
        CLS_TOP     = 2'b11
    } op_class_e;
endpackage

// File: rtl/bdm_classify.sv
module bdm_classify #(
    parameter int N = 8,
    localparam int SW = $clog2(N + 1)
) (
    input  logic [N-1:0]  op,
    output logic          base_zero,
    output logic [SW-1:0] base_shift,
    output logic          neg,
    output logic          extra,
    output logic [N-3:0]  dev
);
    import bdm_pkg::*;

    localparam logic [SW-1:0] SH_Q = SW'(N - 2);
    localparam logic [SW-1:0] SH_H = SW'(N - 1);
    localparam logic [SW-1:0] SH_T = SW'(N);

    logic [N-3:0] low;
    assign low = op[N-3:0];

    always_comb begin
        base_zero  = 1'b0;
        base_shift = '0;
        neg        = 1'b0;
        extra      = 1'b0;
        dev        = low;
        case (op_class_e'(op[N-1:N-2]))
            CLS_SMALL:   base_zero = 1'b1;
            CLS_QUARTER: base_shift = SH_Q;
            CLS_HALF:    base_shift = SH_H;
            CLS_TOP: begin
                if (low == '0) begin
                    // 3*2^(N-2): half anchor plus a quarter term, no deviation
                    base_shift = SH_H;
                    extra      = 1'b1;
                    dev        = '0;
                end else begin
                    base_shift = SH_T;
                    neg        = 1'b1;
                    dev        = ~low + 1'b1;
                end
            end
            default: base_zero = 1'b1;
        endcase
    end
endmodule

// File: rtl/bdm_narrow_mult.sv
module bdm_narrow_mult #(
    parameter int M = 6
) (
    input  logic [M-1:0]   x,
    input  logic [M-1:0]   y,
    output logic [2*M-1:0] prod
);
    logic [2*M-1:0] x_ext;
    assign x_ext = {{M{1'b0}}, x};

    always_comb begin
        prod = '0;
        for (int i = 0; i < M; i++) begin
            if (y[i]) prod = prod + (x_ext << i);
        end
    end
endmodule

// File: rtl/bdm_recombine.sv
module bdm_recombine #(
    parameter int N = 8,
    localparam int SW = $clog2(N + 1),
    localparam int M  = N - 2,
    localparam int PW = 2 * N
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    input  logic           a_base_zero,
    input  logic [SW-1:0]  a_shift,
    input  logic           a_neg,
    input  logic           a_extra,
    input  logic           b_base_zero,
    input  logic [SW-1:0]  b_shift,
    input  logic           b_neg,
    input  logic           b_extra,
    input  logic [M-1:0]   b_dev,
    input  logic [2*M-1:0] dev_prod,
    output logic [PW-1:0]  p
);
    logic [PW-1:0] a_x, rb_x, rr_x;
    logic [PW-1:0] t_anchor, t_extra_b, t_cross, t_dev, t_sum;

    assign a_x  = {{(PW-N){1'b0}}, a};
    assign rb_x = {{(PW-M){1'b0}}, b_dev};
    assign rr_x = {{(PW-2*M){1'b0}}, dev_prod};

    always_comb begin
        // A times anchor of B, plus quarter term when B is 3*2^(N-2)
        t_anchor  = b_base_zero ? '0 : (a_x << b_shift);
        t_extra_b = b_extra ? (a_x << M) : '0;
        // B deviation times anchor of A (and A's quarter term)
        t_cross   = (a_base_zero ? '0 : (rb_x << a_shift))
                  + (a_extra ? (rb_x << M) : '0);
        t_dev     = rr_x;
        // Modulo 2^(2N) arithmetic: the true product always fits
        t_sum     = t_anchor + t_extra_b
                  + (b_neg ? (~t_cross + 1'b1) : t_cross)
                  + ((a_neg ^ b_neg) ? (~t_dev + 1'b1) : t_dev);
        p         = t_sum;
    end
endmodule

// File: rtl/base_dev_mul.sv
module base_dev_mul #(
    parameter int N       = 8,
    parameter int LATENCY = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic           out_valid,
    output logic [2*N-1:0] p
);
    localparam int SW = $clog2(N + 1);
    localparam int M  = N - 2;

    typedef struct packed {
        logic           valid;
        logic [2*N-1:0] prod;
    } out_s;

    logic          a_bz, a_ng, a_ex, b_bz, b_ng, b_ex;
    logic [SW-1:0] a_sh, b_sh;
    logic [M-1:0]  a_dev, b_dev;
    logic [2*M-1:0] dev_prod;
    logic [2*N-1:0] prod_c;
    out_s out_d, out_q;

    bdm_classify #(.N(N)) u_cls_a (
        .op(a), .base_zero(a_bz), .base_shift(a_sh),
        .neg(a_ng), .extra(a_ex), .dev(a_dev)
    );

    bdm_classify #(.N(N)) u_cls_b (
        .op(b), .base_zero(b_bz), .base_shift(b_sh),
        .neg(b_ng), .extra(b_ex), .dev(b_dev)
    );

    bdm_narrow_mult #(.M(M)) u_nmul (
        .x(a_dev), .y(b_dev), .prod(dev_prod)
    );

    bdm_recombine #(.N(N)) u_rec (
        .a(a), .b(b),
        .a_base_zero(a_bz), .a_shift(a_sh), .a_neg(a_ng), .a_extra(a_ex),
        .b_base_zero(b_bz), .b_shift(b_sh), .b_neg(b_ng), .b_extra(b_ex),
        .b_dev(b_dev), .dev_prod(dev_prod), .p(prod_c)
    );

    always_comb begin
        out_d.valid = in_valid;
        out_d.prod  = prod_c;
    end

    generate
        if (LATENCY == 1) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) out_q <= '0;
                else     out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign out_valid = out_q.valid;
    assign p         = out_q.prod;
endmodule

// File: rtl/base_dev_mul_chk.sv
module base_dev_mul_chk #(
    parameter int N       = 8,
    parameter int LATENCY = 1
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic           out_valid,
    input logic [2*N-1:0] p
);
    localparam logic [N-1:0] TOP_ZERO = N'(3) << (N - 2);

    generate
        if (LATENCY == 1) begin : g_l1
            // R1 / R6: registered product of the previous operands
            a_r1_exact: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> p == ({{N{1'b0}}, $past(a)} * {{N{1'b0}}, $past(b)}));
            a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> out_valid == $past(in_valid));
            a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (p == '0 && !out_valid));
            a_r9_zero_operand: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && ($past(a) == '0 || $past(b) == '0)) |-> p == '0);
            a_r3_top_zero_low: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(a) == TOP_ZERO) |->
                p == ({{N{1'b0}}, TOP_ZERO} * {{N{1'b0}}, $past(b)}));
        end else begin : g_l0
            a_r1_exact: assert property (@(posedge clk) disable iff (rst)
                p == ({{N{1'b0}}, a} * {{N{1'b0}}, b}));
            a_r8_valid_comb: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid);
            a_r9_zero_operand: assert property (@(posedge clk) disable iff (rst)
                (a == '0 || b == '0) |-> p == '0);
            a_r3_top_zero_low: assert property (@(posedge clk) disable iff (rst)
                a == TOP_ZERO |-> p == ({{N{1'b0}}, TOP_ZERO} * {{N{1'b0}}, b}));
        end
    endgenerate
endmodule

bind base_dev_mul base_dev_mul_chk #(.N(N), .LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .p(p)
);

// File: tb/test_base_dev_mul.sv
module test_base_dev_mul;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // N=8, registered
    logic        v8_in = 1'b0, v8_out;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    // N=4, combinational
    logic        v4_in = 1'b0, v4_out;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    // N=16, combinational
    logic        v16_in = 1'b0, v16_out;
    logic [15:0] a16 = '0, b16 = '0;
    logic [31:0] p16;

    base_dev_mul #(.N(8), .LATENCY(1)) i_base_dev_mul (
        .clk(clk), .rst(rst), .in_valid(v8_in), .a(a8), .b(b8),
        .out_valid(v8_out), .p(p8));
    base_dev_mul #(.N(4), .LATENCY(0)) i_base_dev_mul_n4 (
        .clk(clk), .rst(rst), .in_valid(v4_in), .a(a4), .b(b4),
        .out_valid(v4_out), .p(p4));
    base_dev_mul #(.N(16), .LATENCY(0)) i_base_dev_mul_n16 (
        .clk(clk), .rst(rst), .in_valid(v16_in), .a(a16), .b(b16),
        .out_valid(v16_out), .p(p16));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one N=8 operation through the register
    task automatic op8(input string req, input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        a8 = x; b8 = y; v8_in = 1'b1;
        @(negedge clk);
        check(req, {16'd0, p8}, 32'(x) * 32'(y));
    endtask

    task automatic t_reset_start;
        a8 = 8'hFF; b8 = 8'hFF; v8_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 reset p", {16'd0, p8}, 32'd0);
        check("R7 reset valid", {31'd0, v8_out}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_n4_exhaustive;
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                a4 = 4'(x); b4 = 4'(y);
                #1;
                check("R1 n4 sweep", {24'd0, p4}, 32'(x * y));
            end
        end
        a4 = 4'd11; b4 = 4'd3; #1;
        check("R5 11x3", {24'd0, p4}, 32'd33);
    endtask

    task automatic t_n8_exhaustive;
        logic [31:0] prev;
        bit have = 1'b0;
        prev = '0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                @(negedge clk);
                if (have) check("R1 n8 sweep", {16'd0, p8}, prev);
                a8 = 8'(x); b8 = 8'(y); v8_in = 1'b1;
                prev = 32'(x * y);
                have = 1'b1;
            end
        end
        @(negedge clk);
        check("R1 n8 sweep last", {16'd0, p8}, prev);
    endtask

    task automatic t_corners8;
        op8("R2 all ones", 8'hFF, 8'hFF);
        op8("R2 top class mixed", 8'hC1, 8'h9A);
        op8("R3 top zero low x ones", 8'hC0, 8'hFF);
        op8("R3 top zero low squared", 8'hC0, 8'hC0);
        op8("R3 top zero low x quarter", 8'h40, 8'hC0);
        op8("R4 small operands", 8'h3F, 8'h3F);
        op8("R4 small x one", 8'h01, 8'h2B);
        op8("R9 zero a", 8'h00, 8'hE7);
        op8("R9 zero b", 8'hB5, 8'h00);
    endtask

    task automatic t_valid8;
        logic [4:0] pat;
        pat = 5'b01101;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i > 0) check("R6 valid delay", {31'd0, v8_out}, {31'd0, pat[i-1]});
            v8_in = pat[i]; a8 = 8'(i + 7); b8 = 8'(i * 13);
        end
        @(negedge clk);
        check("R6 valid delay last", {31'd0, v8_out}, {31'd0, pat[4]});
        check("R6 product delay", {16'd0, p8}, 32'(11 * 52));
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        a8 = 8'hE3; b8 = 8'h77; v8_in = 1'b1;
        @(negedge clk);
        check("R6 before reset", {16'd0, p8}, 32'hE3 * 32'h77);
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid reset p", {16'd0, p8}, 32'd0);
        check("R7 mid reset valid", {31'd0, v8_out}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_lat0;
        v4_in = 1'b1; a4 = 4'd9; b4 = 4'd14; #1;
        check("R8 comb valid high", {31'd0, v4_out}, 32'd1);
        check("R8 comb product", {24'd0, p4}, 32'd126);
        v4_in = 1'b0; a4 = 4'd12; #1;
        check("R8 comb valid low", {31'd0, v4_out}, 32'd0);
        check("R3 n4 top zero low", {24'd0, p4}, 32'd168);
    endtask

    task automatic t_n16;
        logic [15:0] x, y;
        a16 = 16'hFFFF; b16 = 16'hFFFF; #1;
        check("R2 n16 all ones", p16, 32'hFFFE0001);
        a16 = 16'hC000; b16 = 16'hABCD; #1;
        check("R3 n16 top zero low", p16, 32'hC000 * 32'hABCD);
        a16 = 16'h3FFF; b16 = 16'h2001; #1;
        check("R4 n16 small", p16, 32'h3FFF * 32'h2001);
        a16 = 16'h0000; b16 = 16'h9999; #1;
        check("R9 n16 zero", p16, 32'd0);
        for (int i = 0; i < 3000; i++) begin
            x = 16'($urandom); y = 16'($urandom);
            a16 = x; b16 = y; #1;
            check("R1 n16 random", p16, 32'(x) * 32'(y));
        end
    endtask

    initial begin
        t_reset_start();
        t_n4_exhaustive();
        t_lat0();
        t_corners8();
        t_valid8();
        t_reset_mid();
        t_n16();
        t_n8_exhaustive();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule